// File: doc/BRIEF.md
# Input Port with Change Detection

This block is the general-purpose input port of a dual serial controller. Six external input pins pass through a two-flop synchronizer on the main clock. The CPU reads them as a port register in which each bit is the complement of its pin. The synchronized levels are also the source for any alternate pin functions, such as a clear-to-send input or an external clock, which other blocks decode.

The lower four inputs each have a change detector. A free-running divider makes a one-cycle sampling tick every 96 main-clock cycles. A detector accepts a new level only when two ticks in a row sample the same level and that level differs from the one last accepted. Rising and falling edges both count. An accepted change sets a sticky delta flag in a change register, and reading that register clears the flags. The interrupt request is the OR of the delta flags, each gated by a bit of an enable mask.

Top module: `inport_cos`

## Requirements
- R1: A read with `rd_i` high at address 0xD returns the complement of the six synchronized pins in bits 5:0 (bit n is input n) and zero in bits 7:6. A read at an unmapped address, or with `rd_i` low, returns 0x00.
- R2: A pin change is absent from a port read taken one clock edge after the change and present in a read taken two edges after it.
- R3: The sampling tick occurs at every 96th clock edge after reset is released, starting with the 96th.
- R4: A change is accepted only when the same new level is sampled on two consecutive ticks. A level that is held long enough to be seen by only one tick sets no flag.
- R5: Inputs 0 to 3 flag changes in both directions. Inputs 4 and 5 never set a change flag.
- R6: A read at address 0x4 returns the delta flags of inputs 3..0 in bits 7:4 (bit 4 is input 0) and the complement of the accepted levels of inputs 3..0 in bits 3:0 (bit 0 is input 0). After reset the accepted levels are low, so the register reads 0x0F.
- R7: A read at address 0x4 returns the flags as they were before the read and clears them at that clock edge. Flags otherwise stay set.
- R8: A change accepted at the same edge as a clearing read leaves its flag set. Other flags are cleared by that read.
- R9: `irq_o` is high exactly when some delta flag n is set with `mask_i[n]` high. It stays high until the change register is read.
- R10: During and after reset all delta flags are clear and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 6 | Raw external input pins |
| rd_i | input | 1 | CPU read strobe |
| addr_i | input | 4 | CPU register address |
| mask_i | input | 4 | Interrupt enable per detected input |
| rdata_o | output | 8 | Read data, combinational while `rd_i` is high |
| sync_o | output | 6 | Synchronized pin levels for alternate functions |
| irq_o | output | 1 | Interrupt request |

## Verification
Read data is combinational, so the bench samples it 1 ns after driving a read at a falling edge. A pin change appears in the port register two rising edges after it is driven. The bench counts rising edges since reset and drives each detector stimulus on the falling edge that follows a tick. The flag is therefore due exactly at the second tick after that, 192 edges later. The bench confirms the flag is absent at the first tick and present at the second. It also places a clearing read precisely on the edge where a change is accepted. The interrupt and the clear are checked on the falling edge after the edge that sets or clears the flag.

// File: rtl/inport_pkg.sv
package inport_pkg;
  localparam int unsigned N_IN   = 6;
  localparam int unsigned N_COS  = 4;
  localparam int unsigned DIV    = 96;
  localparam int unsigned AW     = 4;
  localparam int unsigned DW     = 8;
  localparam logic [AW-1:0] ADDR_PORT = 4'hD;
  localparam logic [AW-1:0] ADDR_CHG  = 4'h4;
endpackage

// File: rtl/inport_sync.sv
module inport_sync #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/inport_tick.sv
module inport_tick #(
  parameter int unsigned DIV = 96
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  p_cnt_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  p_tick_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/inport_cos.sv
module inport_cos_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic lvl_i,
  input  logic clr_i,
  output logic qual_o,
  output logic delta_o
);
  logic cand_q, qual_q, delta_q;
  logic accept;

  // new level must match the previous tick sample and differ from accepted
  assign accept = tick_i && (lvl_i == cand_q) && (lvl_i != qual_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_q  <= 1'b0;
      qual_q  <= 1'b0;
      delta_q <= 1'b0;
    end else begin
      if (tick_i) cand_q <= lvl_i;
      if (accept) qual_q <= lvl_i;
      delta_q <= accept | (delta_q & ~clr_i);
    end
  end

  assign qual_o  = qual_q;
  assign delta_o = delta_q;

  p_flag_on_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(delta_q) |-> $past(tick_i));
  p_qual_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(qual_q));
  p_qual_flags_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(qual_q) |-> delta_q);
  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    delta_q && !clr_i |=> delta_q);
  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !tick_i |=> !delta_q);
  p_keep_on_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && clr_i && (lvl_i == cand_q) && (lvl_i != qual_q) |=> delta_q);
endmodule

// File: rtl/inport_top.sv
module inport_cos
  import inport_pkg::*;
#(
  parameter int unsigned NIN  = N_IN,
  parameter int unsigned NCOS = N_COS,
  parameter int unsigned TDIV = DIV
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NIN-1:0]  pin_i,
  input  logic            rd_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [NCOS-1:0] mask_i,
  output logic [DW-1:0]   rdata_o,
  output logic [NIN-1:0]  sync_o,
  output logic            irq_o
);
  localparam int unsigned PAD = DW - NIN;

  logic [NIN-1:0]  lvl;
  logic [NCOS-1:0] qual, delta;
  logic            tick, clr;

  inport_sync #(.W(NIN)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(lvl)
  );

  inport_tick #(.DIV(TDIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  assign clr = rd_i && (addr_i == ADDR_CHG);

  for (genvar i = 0; i < NCOS; i++) begin : g_cos
    inport_cos_bit u_bit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick),
      .lvl_i  (lvl[i]),
      .clr_i  (clr),
      .qual_o (qual[i]),
      .delta_o(delta[i])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        ADDR_PORT: rdata_o = {{PAD{1'b0}}, ~lvl};
        ADDR_CHG:  rdata_o = {delta, ~qual};
        default:   rdata_o = '0;
      endcase
    end
  end

  assign sync_o = lvl;
  assign irq_o  = |(delta & mask_i);

  p_irq_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr && !tick |=> !irq_o);
  p_irq_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !clr && $stable(mask_i) |=> irq_o);
  p_idle_read_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rdata_o == '0);
endmodule

// File: tb/tb_inport_cos.sv
module tb_inport_cos;
  localparam int CLK_PERIOD = 10;
  localparam int TICK = 96;

  logic       clk, rst_ni, rd;
  logic [5:0] pins;
  logic [3:0] addr, mask;
  logic [7:0] rdata;
  logic [5:0] sync;
  logic       irq;
  int total = 0, bad = 0, cyc = 0;
  logic [7:0] d;

  inport_cos dut (
    .clk_i(clk), .rst_ni(rst_ni), .pin_i(pins), .rd_i(rd), .addr_i(addr),
    .mask_i(mask), .rdata_o(rdata), .sync_o(sync), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rst_ni) cyc <= cyc + 1;

  // {pins, mask, port, chg, irq}; each applied from the previous pin state
  localparam logic [26:0] VECS [6] = '{
    {6'h01, 4'h1, 8'h3E, 8'h1E, 1'b1},
    {6'h21, 4'hF, 8'h1E, 8'h0E, 1'b0},
    {6'h0E, 4'h1, 8'h31, 8'hF1, 1'b1},
    {6'h06, 4'h4, 8'h39, 8'h89, 1'b0},
    {6'h10, 4'h8, 8'h2F, 8'h6F, 1'b0},
    {6'h1F, 4'h2, 8'h20, 8'hF0, 1'b1}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd = 1'b0; addr = '0;
  endtask

  task automatic align(output int t);
    do @(negedge clk); while (cyc % TICK != 0);
    t = cyc;
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    int t0;
    rst_ni = 1'b0; rd = 1'b0; addr = '0; mask = '0; pins = '0;
    repeat (3) @(negedge clk);
    #1 chk("R10 irq in reset", {7'b0, irq}, 8'h00);
    rst_ni = 1'b1;

    rd_reg(4'hD, d); chk("R1 port after reset", d, 8'h3F);
    rd_reg(4'h4, d); chk("R6 chg after reset", d, 8'h0F);
    rd_reg(4'h0, d); chk("R1 unmapped addr", d, 8'h00);
    #1 chk("R1 idle read", rdata, 8'h00);
    chk("R10 irq after reset", {7'b0, irq}, 8'h00);

    // vector table: the flag is due at the second tick after the change
    for (int v = 0; v < 6; v++) begin
      align(t0);
      {pins, mask} = VECS[v][26:17];
      wait_to(t0 + TICK);
      rd_reg(4'h4, d);
      chk($sformatf("R4 vec%0d no flag after one tick", v), {d[7:4], 4'h0}, 8'h00);
      wait_to(t0 + 2*TICK);
      #1 chk($sformatf("R9 vec%0d irq", v), {7'b0, irq}, {7'b0, VECS[v][0]});
      rd_reg(4'hD, d);
      chk($sformatf("R1 vec%0d port", v), d, VECS[v][16:9]);
      rd_reg(4'h4, d);
      chk($sformatf("R6 R5 vec%0d chg", v), d, VECS[v][8:1]);
      rd_reg(4'h4, d);
      chk($sformatf("R7 vec%0d cleared", v), {d[7:4], 4'h0}, 8'h00);
      #1 chk($sformatf("R7 vec%0d irq cleared", v), {7'b0, irq}, 8'h00);
    end

    // R2: two synchronizer stages before the port register sees the pin
    @(negedge clk); pins[5] = 1'b1;
    @(negedge clk); addr = 4'hD; rd = 1'b1;
    #1 chk("R2 port after one edge", rdata, 8'h20);
    @(negedge clk);
    #1 chk("R2 port after two edges", rdata, 8'h00);
    rd = 1'b0; addr = '0;

    // R4: a level seen by only one tick is rejected
    align(t0);
    pins[0] = 1'b0;
    repeat (100) @(negedge clk);
    pins[0] = 1'b1;
    wait_to(t0 + 2*TICK + 8);
    rd_reg(4'h4, d); chk("R4 glitch rejected", d, 8'h00);
    wait_to(t0 + 3*TICK + 4);
    rd_reg(4'h4, d); chk("R4 glitch still rejected", d, 8'h00);

    // R8: clearing read on the same edge that accepts a new change
    align(t0);
    pins[1] = 1'b0;
    align(t0);
    pins[2] = 1'b0;
    wait_to(t0 + 2*TICK - 1);
    addr = 4'h4; rd = 1'b1;
    #1 chk("R3 R8 read before accept", rdata, 8'h22);
    @(negedge clk); rd = 1'b0; addr = '0;
    rd_reg(4'h4, d); chk("R8 new flag kept, old cleared", d, 8'h46);
    rd_reg(4'h4, d); chk("R7 after second read", d, 8'h06);

    // R9: mask gating and hold until read
    align(t0);
    mask = 4'h0;
    pins[3] = 1'b0;
    wait_to(t0 + 2*TICK);
    #1 chk("R9 masked irq", {7'b0, irq}, 8'h00);
    mask = 4'h8;
    #1 chk("R9 unmasked irq", {7'b0, irq}, 8'h01);
    repeat (50) @(negedge clk);
    #1 chk("R9 irq held", {7'b0, irq}, 8'h01);
    rd_reg(4'h4, d); chk("R5 falling change on input 3", d, 8'h8E);
    #1 chk("R9 irq dropped after read", {7'b0, irq}, 8'h00);

    finish_run();
  end
endmodule